// File: doc/BRIEF.md
# Data-Space Address Router

This block steers every data access of a small processor core into one 16-bit data address space. Three request sources feed it. Load/store requests carry a full 16-bit address. Port requests carry a 6-bit I/O address. Bit requests carry a 5-bit I/O address, a bit index and an operation. One request is taken per clock cycle. The block turns it into a region select and an offset within that region. The regions are the I/O registers, a non-volatile/fuse window, SRAM and a read-only flash window. The region stores inside the block are simple stubs, and each one populates only the lowest part of its region, as set by a depth parameter.

Bit set and bit clear are atomic read-modify-write operations on the lowest 32 I/O locations, and each completes in a single cycle. A bit test returns the selected bit as a flag. A separate program-memory read port reads the same flash contents, using addresses that start at zero. Reads answer one cycle after the request. Writes that cannot land produce a one-cycle error strobe.

Top module: `dspace_router`

## Requirements
- R1: A load/store address decodes to a region as follows. 0x0000–0x0FFF is I/O. 0x1000–0x17FF is the non-volatile window. 0x1800–0x7FFF is SRAM. 0x8000–0xFFFF is flash. The offset is the address minus the region base. A written byte reads back at the same address in I/O, the non-volatile window and SRAM.
- R2: A 6-bit port address P reaches data address P (0x00–0x3F). A port write is visible to a load/store read of the same address, and a load/store write is visible to a port read.
- R3: Extended I/O at 0x0040–0x0FFF is reached only by load/store. A write there leaves the locations at 0x00–0x3F unchanged.
- R4: A bit request acts on data address 0x00–0x1F. bo_op 2'b00 sets and 2'b01 clears bit bo_bit in one cycle, and every other bit keeps its value. bo_op 2'b11 does nothing.
- R5: bo_op 2'b10 (test) raises tst_valid one cycle later, with tst_flag equal to the selected bit. The register is not written.
- R6: Flash byte at offset F holds F[7:0] XOR 0x5A. It reads at data address 0x8000+F. On the program port it reads at pm_addr F, with pm_data registered one cycle later. A program read at or beyond FLASH_DEPTH returns 0x00.
- R7: A write to the flash window, or to an offset at or beyond the populated depth of its region, changes no store. err_pulse is high for exactly the cycle after that write.
- R8: A read of an offset at or beyond the populated depth of its region returns 0x00.
- R9: When more than one request is raised in the same cycle, load/store wins over port, and port wins over bit. The losing requests have no effect.
- R10: After reset, rd_valid, tst_valid and err_pulse are low, and every store location reads 0x00.
- R11: A read request (load/store or port) gives rd_valid and rd_data in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ls_req | input | 1 | Load/store request |
| ls_we | input | 1 | Load/store write (1) or read (0) |
| ls_addr | input | 16 | Full data address |
| ls_wdata | input | 8 | Load/store write data |
| pt_req | input | 1 | Port request |
| pt_we | input | 1 | Port write (1) or read (0) |
| pt_addr | input | PT_AW | Short I/O address |
| pt_wdata | input | 8 | Port write data |
| bo_req | input | 1 | Bit request |
| bo_op | input | 2 | 00 set, 01 clear, 10 test, 11 none |
| bo_addr | input | BO_AW | Bit-addressable register |
| bo_bit | input | 3 | Bit index |
| pm_addr | input | PM_AW | Program-memory read address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| tst_valid | output | 1 | Bit test result valid |
| tst_flag | output | 1 | Tested bit value |
| err_pulse | output | 1 | Rejected write strobe |
| pm_data | output | 8 | Program-memory read data |

## Verification
The bench builds the block with its default parameters. These are 128 I/O locations, 32 non-volatile locations, 256 SRAM locations and 128 flash locations, so each region has an unpopulated hole just above its populated part. Because the depths are small, the bench can read and write the last populated byte and the first hole byte of each region. Extended I/O at 0x0040 stays populated, which lets the bench show that load/store reaches it and that the port window does not alias onto it. With a 15-bit program port, a program read past the flash depth also falls within reach.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

   localparam int ADDR_W = 16;

   localparam logic [ADDR_W-1:0] NVM_BASE   = 16'h1000;
   localparam logic [ADDR_W-1:0] SRAM_BASE  = 16'h1800;
   localparam logic [ADDR_W-1:0] FLASH_BASE = 16'h8000;

   typedef enum logic [1:0] {
      RG_IO    = 2'd0,
      RG_NVM   = 2'd1,
      RG_SRAM  = 2'd2,
      RG_FLASH = 2'd3
   } region_e;

   typedef enum logic [1:0] {
      BO_SET = 2'b00,
      BO_CLR = 2'b01,
      BO_TST = 2'b10,
      BO_NOP = 2'b11
   } bitop_e;

   typedef enum logic [2:0] {
      K_IDLE = 3'd0,
      K_RD   = 3'd1,
      K_WR   = 3'd2,
      K_BSET = 3'd3,
      K_BCLR = 3'd4,
      K_BTST = 3'd5
   } kind_e;

   typedef struct packed {
      kind_e             kind;
      logic [ADDR_W-1:0] addr;
      logic [7:0]        wdata;
      logic [2:0]        bitsel;
   } xfer_t;

   // Flash stub contents: low offset byte scrambled with a constant
   function automatic logic [7:0] flash_byte(input logic [ADDR_W-1:0] off);
      return off[7:0] ^ 8'h5A;
   endfunction

endpackage

// File: rtl/dsr_arbiter.sv
module dsr_arbiter
   import dsr_pkg::*;
#(
   parameter int PT_AW = 6,
   parameter int BO_AW = 5
)(
   input  logic              ls_req,
   input  logic              ls_we,
   input  logic [ADDR_W-1:0] ls_addr,
   input  logic [7:0]        ls_wdata,
   input  logic              pt_req,
   input  logic              pt_we,
   input  logic [PT_AW-1:0]  pt_addr,
   input  logic [7:0]        pt_wdata,
   input  logic              bo_req,
   input  logic [1:0]        bo_op,
   input  logic [BO_AW-1:0]  bo_addr,
   input  logic [2:0]        bo_bit,
   output xfer_t             xfer
);

   localparam int PT_PAD = ADDR_W - PT_AW;
   localparam int BO_PAD = ADDR_W - BO_AW;

   generate
      if (!(BO_AW < PT_AW && PT_AW < ADDR_W)) begin : g_bad_widths
         $error("dsr_arbiter: need BO_AW < PT_AW < ADDR_W");
      end
   endgenerate

   always_comb begin
      xfer = '0;
      if (ls_req) begin
         xfer.kind  = ls_we ? K_WR : K_RD;
         xfer.addr  = ls_addr;
         xfer.wdata = ls_wdata;
      end else if (pt_req) begin
         xfer.kind  = pt_we ? K_WR : K_RD;
         xfer.addr  = {{PT_PAD{1'b0}}, pt_addr};
         xfer.wdata = pt_wdata;
      end else if (bo_req) begin
         xfer.addr   = {{BO_PAD{1'b0}}, bo_addr};
         xfer.bitsel = bo_bit;
         case (bitop_e'(bo_op))
            BO_SET:  xfer.kind = K_BSET;
            BO_CLR:  xfer.kind = K_BCLR;
            BO_TST:  xfer.kind = K_BTST;
            default: xfer.kind = K_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dsr_decode.sv
module dsr_decode
   import dsr_pkg::*;
#(
   parameter int IO_DEPTH    = 128,
   parameter int NVM_DEPTH   = 32,
   parameter int SRAM_DEPTH  = 256,
   parameter int FLASH_DEPTH = 128
)(
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [ADDR_W-1:0] off,
   output logic              populated
);

   localparam logic [ADDR_W-1:0] IO_LIM    = ADDR_W'(IO_DEPTH);
   localparam logic [ADDR_W-1:0] NVM_LIM   = ADDR_W'(NVM_DEPTH);
   localparam logic [ADDR_W-1:0] SRAM_LIM  = ADDR_W'(SRAM_DEPTH);
   localparam logic [ADDR_W-1:0] FLASH_LIM = ADDR_W'(FLASH_DEPTH);

   always_comb begin
      if (addr < NVM_BASE) begin
         region    = RG_IO;
         off       = addr;
         populated = off < IO_LIM;
      end else if (addr < SRAM_BASE) begin
         region    = RG_NVM;
         off       = addr - NVM_BASE;
         populated = off < NVM_LIM;
      end else if (addr < FLASH_BASE) begin
         region    = RG_SRAM;
         off       = addr - SRAM_BASE;
         populated = off < SRAM_LIM;
      end else begin
         region    = RG_FLASH;
         off       = addr - FLASH_BASE;
         populated = off < FLASH_LIM;
      end
   end

endmodule

// File: rtl/dsr_store.sv
module dsr_store
   import dsr_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter bit READ_ONLY = 1'b0,
   localparam int OW       = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [OW-1:0] idx,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);

   generate
      if (DEPTH < 2 || (1 << OW) != DEPTH) begin : g_bad_depth
         $error("dsr_store: DEPTH must be a power of two of at least 2");
      end

      if (READ_ONLY) begin : g_rom
         logic unused_wr;
         assign unused_wr = ^{clk, rst_n, we, wdata};
         assign rdata     = flash_byte(ADDR_W'(idx));
      end else begin : g_ram
         logic [7:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[idx] <= wdata;
            end
         end
         assign rdata = mem[idx];
      end
   endgenerate

endmodule

// File: rtl/dspace_router.sv
module dspace_router
   import dsr_pkg::*;
#(
   parameter int PT_AW       = 6,
   parameter int BO_AW       = 5,
   parameter int PM_AW       = 15,
   parameter int IO_DEPTH    = 128,
   parameter int NVM_DEPTH   = 32,
   parameter int SRAM_DEPTH  = 256,
   parameter int FLASH_DEPTH = 128
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ls_req,
   input  logic             ls_we,
   input  logic [15:0]      ls_addr,
   input  logic [7:0]       ls_wdata,
   input  logic             pt_req,
   input  logic             pt_we,
   input  logic [PT_AW-1:0] pt_addr,
   input  logic [7:0]       pt_wdata,
   input  logic             bo_req,
   input  logic [1:0]       bo_op,
   input  logic [BO_AW-1:0] bo_addr,
   input  logic [2:0]       bo_bit,
   input  logic [PM_AW-1:0] pm_addr,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             tst_valid,
   output logic             tst_flag,
   output logic             err_pulse,
   output logic [7:0]       pm_data
);

   localparam int IO_OW    = $clog2(IO_DEPTH);
   localparam int NVM_OW   = $clog2(NVM_DEPTH);
   localparam int SRAM_OW  = $clog2(SRAM_DEPTH);
   localparam int FLASH_OW = $clog2(FLASH_DEPTH);
   localparam int PT_SPAN  = 1 << PT_AW;

   generate
      if (IO_DEPTH < PT_SPAN || IO_DEPTH > 4096) begin : g_bad_io
         $error("dspace_router: IO_DEPTH must cover the port window and fit 4 KB");
      end
      if (NVM_DEPTH > 2048) begin : g_bad_nvm
         $error("dspace_router: NVM_DEPTH exceeds its window");
      end
      if (SRAM_DEPTH > 26624) begin : g_bad_sram
         $error("dspace_router: SRAM_DEPTH exceeds its window");
      end
      if (FLASH_DEPTH > 32768 || PM_AW > 15) begin : g_bad_flash
         $error("dspace_router: flash depth or program port too wide");
      end
   endgenerate

   xfer_t             xfer;
   region_e           dec_region;
   logic [ADDR_W-1:0] dec_off;
   logic              dec_pop;

   dsr_arbiter #(.PT_AW(PT_AW), .BO_AW(BO_AW)) u_arb (
      .ls_req   (ls_req),
      .ls_we    (ls_we),
      .ls_addr  (ls_addr),
      .ls_wdata (ls_wdata),
      .pt_req   (pt_req),
      .pt_we    (pt_we),
      .pt_addr  (pt_addr),
      .pt_wdata (pt_wdata),
      .bo_req   (bo_req),
      .bo_op    (bo_op),
      .bo_addr  (bo_addr),
      .bo_bit   (bo_bit),
      .xfer     (xfer)
   );

   dsr_decode #(
      .IO_DEPTH   (IO_DEPTH),
      .NVM_DEPTH  (NVM_DEPTH),
      .SRAM_DEPTH (SRAM_DEPTH),
      .FLASH_DEPTH(FLASH_DEPTH)
   ) u_dec (
      .addr      (xfer.addr),
      .region    (dec_region),
      .off       (dec_off),
      .populated (dec_pop)
   );

   // Request classification
   logic is_wr, is_rd, is_bset, is_bclr, is_btst, is_bmod;
   assign is_wr   = (xfer.kind == K_WR);
   assign is_rd   = (xfer.kind == K_RD);
   assign is_bset = (xfer.kind == K_BSET);
   assign is_bclr = (xfer.kind == K_BCLR);
   assign is_btst = (xfer.kind == K_BTST);
   assign is_bmod = is_bset | is_bclr;

   logic wr_lands;
   assign wr_lands = is_wr && dec_pop && (dec_region != RG_FLASH);

   // Region stores
   logic [7:0] io_rd, nvm_rd, sram_rd, flash_rd;
   logic       io_we, nvm_we, sram_we;
   logic [7:0] io_wdata;
   logic [7:0] bit_mask;

   assign bit_mask = 8'b1 << xfer.bitsel;
   assign io_we    = (wr_lands && dec_region == RG_IO) || is_bmod;
   assign nvm_we   = wr_lands && dec_region == RG_NVM;
   assign sram_we  = wr_lands && dec_region == RG_SRAM;

   always_comb begin
      if (is_bset)      io_wdata = io_rd | bit_mask;
      else if (is_bclr) io_wdata = io_rd & ~bit_mask;
      else              io_wdata = xfer.wdata;
   end

   dsr_store #(.DEPTH(IO_DEPTH), .READ_ONLY(1'b0)) u_io (
      .clk(clk), .rst_n(rst_n), .we(io_we), .idx(dec_off[IO_OW-1:0]),
      .wdata(io_wdata), .rdata(io_rd)
   );

   dsr_store #(.DEPTH(NVM_DEPTH), .READ_ONLY(1'b0)) u_nvm (
      .clk(clk), .rst_n(rst_n), .we(nvm_we), .idx(dec_off[NVM_OW-1:0]),
      .wdata(xfer.wdata), .rdata(nvm_rd)
   );

   dsr_store #(.DEPTH(SRAM_DEPTH), .READ_ONLY(1'b0)) u_sram (
      .clk(clk), .rst_n(rst_n), .we(sram_we), .idx(dec_off[SRAM_OW-1:0]),
      .wdata(xfer.wdata), .rdata(sram_rd)
   );

   dsr_store #(.DEPTH(FLASH_DEPTH), .READ_ONLY(1'b1)) u_flash (
      .clk(clk), .rst_n(rst_n), .we(1'b0), .idx(dec_off[FLASH_OW-1:0]),
      .wdata(8'h00), .rdata(flash_rd)
   );

   // Read return mux
   logic [7:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (dec_pop) begin
         case (dec_region)
            RG_IO:    rd_mux = io_rd;
            RG_NVM:   rd_mux = nvm_rd;
            RG_SRAM:  rd_mux = sram_rd;
            default:  rd_mux = flash_rd;
         endcase
      end
   end

   // Program-memory side path
   logic [7:0] pm_next;
   assign pm_next = (32'(pm_addr) < FLASH_DEPTH) ? flash_byte(ADDR_W'(pm_addr)) : 8'h00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         tst_valid <= 1'b0;
         tst_flag  <= 1'b0;
         err_pulse <= 1'b0;
         pm_data   <= '0;
      end else begin
         rd_valid  <= is_rd;
         rd_data   <= rd_mux;
         tst_valid <= is_btst;
         tst_flag  <= io_rd[xfer.bitsel];
         err_pulse <= is_wr && !wr_lands;
         pm_data   <= pm_next;
      end
   end

endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
   parameter int NVM_DEPTH = 32
)(
   input logic        clk,
   input logic        rst_n,
   input logic        ls_req,
   input logic        ls_we,
   input logic [15:0] ls_addr,
   input logic        pt_req,
   input logic        bo_req,
   input logic [1:0]  bo_op,
   input logic        io_we,
   input logic        rd_valid,
   input logic [7:0]  rd_data,
   input logic        tst_valid,
   input logic        err_pulse
);

   localparam logic [15:0] NVM_HOLE = 16'(32'h1000 + NVM_DEPTH);

   p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ls_req && !ls_we |=> rd_valid);

   p_flash_write_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ls_req && ls_we && ls_addr[15] |=> err_pulse);

   p_hole_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ls_req && !ls_we && ls_addr >= NVM_HOLE && ls_addr < 16'h1800 |=> rd_data == 8'h00);

   p_test_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bo_req && !ls_req && !pt_req && bo_op == 2'b10 |-> !io_we);

   p_loadstore_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ls_req |=> !tst_valid);

endmodule

bind dspace_router dsr_checker #(.NVM_DEPTH(NVM_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ls_req    (ls_req),
   .ls_we     (ls_we),
   .ls_addr   (ls_addr),
   .pt_req    (pt_req),
   .bo_req    (bo_req),
   .bo_op     (bo_op),
   .io_we     (io_we),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .tst_valid (tst_valid),
   .err_pulse (err_pulse)
);

// File: tb/sim_dspace_router.sv
module sim_dspace_router;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ls_req = 0, ls_we = 0;
   logic [15:0] ls_addr = 0;
   logic [7:0]  ls_wdata = 0;
   logic        pt_req = 0, pt_we = 0;
   logic [5:0]  pt_addr = 0;
   logic [7:0]  pt_wdata = 0;
   logic        bo_req = 0;
   logic [1:0]  bo_op = 0;
   logic [4:0]  bo_addr = 0;
   logic [2:0]  bo_bit = 0;
   logic [14:0] pm_addr = 0;
   logic        rd_valid, tst_valid, tst_flag, err_pulse;
   logic [7:0]  rd_data, pm_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   dspace_router u0 (.*);

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   typedef struct {
      bit       rv;
      bit [7:0] rd;
      bit       tv;
      bit       tf;
      bit       er;
      bit [7:0] pm;
      string    tag;
   } exp_t;

   exp_t q[$];

   // Reference stores built from R1, R6, R8, R10
   bit [7:0] m_io   [128];
   bit [7:0] m_nvm  [32];
   bit [7:0] m_sram [256];

   function automatic bit [7:0] m_read(input bit [15:0] a);
      bit [15:0] o;
      if (a < 16'h1000) return (a < 128) ? m_io[a] : 8'h00;
      if (a < 16'h1800) begin o = a - 16'h1000; return (o < 32) ? m_nvm[o] : 8'h00; end
      if (a < 16'h8000) begin o = a - 16'h1800; return (o < 256) ? m_sram[o] : 8'h00; end
      o = a - 16'h8000;
      return (o < 128) ? (o[7:0] ^ 8'h5A) : 8'h00;
   endfunction

   function automatic bit m_write(input bit [15:0] a, input bit [7:0] d);
      bit [15:0] o;
      if (a < 16'h1000) begin
         if (a < 128) begin m_io[a] = d; return 0; end
         return 1;
      end
      if (a < 16'h1800) begin
         o = a - 16'h1000;
         if (o < 32) begin m_nvm[o] = d; return 0; end
         return 1;
      end
      if (a < 16'h8000) begin
         o = a - 16'h1800;
         if (o < 256) begin m_sram[o] = d; return 0; end
         return 1;
      end
      return 1;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the expected response
   task automatic step(input bit lr, input bit lw, input bit [15:0] la, input bit [7:0] lwd,
                       input bit pr, input bit pw, input bit [5:0] pa, input bit [7:0] pwd,
                       input bit br, input bit [1:0] bop, input bit [4:0] ba, input bit [2:0] bb,
                       input bit [14:0] pma, input string tag);
      exp_t e;
      @(negedge clk); #1;
      ls_req = lr; ls_we = lw; ls_addr = la; ls_wdata = lwd;
      pt_req = pr; pt_we = pw; pt_addr = pa; pt_wdata = pwd;
      bo_req = br; bo_op = bop; bo_addr = ba; bo_bit = bb;
      pm_addr = pma;
      e = '{rv: 0, rd: 0, tv: 0, tf: 0, er: 0, pm: 0, tag: tag};
      if (lr) begin
         if (lw) e.er = m_write(la, lwd);
         else begin e.rv = 1; e.rd = m_read(la); end
      end else if (pr) begin
         if (pw) e.er = m_write({10'b0, pa}, pwd);
         else begin e.rv = 1; e.rd = m_read({10'b0, pa}); end
      end else if (br) begin
         case (bop)
            2'b00: m_io[ba][bb] = 1'b1;
            2'b01: m_io[ba][bb] = 1'b0;
            2'b10: begin e.tv = 1; e.tf = m_io[ba][bb]; end
            default: ;
         endcase
      end
      e.pm = (pma < 128) ? (pma[7:0] ^ 8'h5A) : 8'h00;
      q.push_back(e);
   endtask

   task automatic ls_wr(input bit [15:0] a, input bit [7:0] d, input string t);
      step(1, 1, a, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, t);
   endtask
   task automatic ls_rd(input bit [15:0] a, input string t);
      step(1, 0, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, t);
   endtask
   task automatic pt_wr(input bit [5:0] a, input bit [7:0] d, input string t);
      step(0, 0, 0, 0, 1, 1, a, d, 0, 0, 0, 0, 0, t);
   endtask
   task automatic pt_rd(input bit [5:0] a, input string t);
      step(0, 0, 0, 0, 1, 0, a, 0, 0, 0, 0, 0, 0, t);
   endtask
   task automatic bit_op(input bit [1:0] op, input bit [4:0] a, input bit [2:0] b, input string t);
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, op, a, b, 0, t);
   endtask
   task automatic pm_rd(input bit [14:0] a, input string t);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, a, t);
   endtask

   // Monitor: pops one expectation per cycle and compares it
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(rd_valid == e.rv, {e.tag, " rd_valid"}, rd_valid, e.rv);
         if (e.rv) check(rd_data == e.rd, {e.tag, " rd_data"}, rd_data, e.rd);
         check(tst_valid == e.tv, {e.tag, " tst_valid"}, tst_valid, e.tv);
         if (e.tv) check(tst_flag == e.tf, {e.tag, " tst_flag"}, tst_flag, e.tf);
         check(err_pulse == e.er, {e.tag, " err_pulse"}, err_pulse, e.er);
         check(pm_data == e.pm, {e.tag, " pm_data"}, pm_data, e.pm);
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); #1 rst_n = 1'b1;
      // R10: outputs idle out of reset
      check(rd_valid == 0 && tst_valid == 0 && err_pulse == 0, "R10 reset outputs",
            {rd_valid, tst_valid, err_pulse}, 0);
      ls_rd(16'h0005, "R10 io cleared");
      ls_rd(16'h1000, "R10 nvm cleared");
      ls_rd(16'h18FF, "R10 sram cleared");

      ls_wr(16'h0005, 8'h3C, "R1 io write");
      ls_rd(16'h0005, "R1 R11 io read");
      ls_wr(16'h1003, 8'hAB, "R1 nvm write");
      ls_rd(16'h1003, "R1 nvm read");
      ls_wr(16'h1800, 8'h11, "R1 sram base write");
      ls_wr(16'h18FF, 8'hEE, "R1 sram top write");
      ls_rd(16'h1800, "R1 sram base read");
      ls_rd(16'h18FF, "R1 sram top read");

      ls_wr(16'h0041, 8'h77, "R3 ext io write");
      ls_rd(16'h0041, "R3 ext io read");
      ls_rd(16'h0001, "R3 low io untouched");

      pt_wr(6'h3F, 8'h99, "R2 port write");
      ls_rd(16'h003F, "R2 ls sees port");
      ls_wr(16'h0010, 8'h12, "R2 ls write");
      pt_rd(6'h10, "R2 port sees ls");

      ls_rd(16'h8000, "R6 flash base");
      ls_rd(16'h8011, "R6 flash offset");
      pm_rd(15'h0011, "R6 pm read");
      pm_rd(15'h007F, "R6 pm last");
      pm_rd(15'h0080, "R6 pm beyond");

      ls_wr(16'h8002, 8'h00, "R7 flash write");
      ls_rd(16'h8002, "R7 flash unchanged");
      ls_wr(16'h1020, 8'h55, "R7 nvm hole write");
      ls_rd(16'h1020, "R8 nvm hole read");
      ls_wr(16'h1900, 8'h66, "R7 sram hole write");
      ls_rd(16'h1900, "R8 sram hole read");
      ls_rd(16'h0080, "R8 io hole read");
      ls_rd(16'hFFFF, "R8 flash hole read");

      bit_op(2'b00, 5'h05, 3'd0, "R4 set bit0");
      bit_op(2'b01, 5'h05, 3'd5, "R4 clear bit5");
      pt_rd(6'h05, "R4 after set clear");
      bit_op(2'b10, 5'h05, 3'd4, "R5 test one");
      bit_op(2'b10, 5'h05, 3'd1, "R5 test zero");
      ls_rd(16'h0005, "R5 no write");
      bit_op(2'b00, 5'h1F, 3'd7, "R4 set top reg");
      ls_rd(16'h001F, "R4 top reg read");
      bit_op(2'b11, 5'h05, 3'd2, "R4 nop op");
      ls_rd(16'h0005, "R4 nop unchanged");

      step(1, 0, 16'h0005, 0, 1, 1, 6'h05, 8'hFF, 1, 2'b00, 5'h05, 3'd7, 0, "R9 ls over all");
      ls_rd(16'h0005, "R9 losers dropped");
      step(0, 0, 0, 0, 1, 1, 6'h06, 8'hA0, 1, 2'b10, 5'h06, 3'd7, 0, "R9 port over bit");
      pt_rd(6'h06, "R9 port write landed");

      @(negedge clk); #1 ls_req = 0; pt_req = 0; bo_req = 0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule